// File: doc/BRIEF.md
# Trap cause priority selector

This block sits at the point where an instruction is either committed or turned into a trap. Each cycle it receives the set of exception conditions raised for the instruction currently there, plus a strobe saying an execution attempt is being made for that instruction. When the strobe is high and at least one condition is present, the block keeps only the single most urgent condition. One cycle later it raises a trap request and presents the 32-bit value meant for the machine cause register.

Conditions that come from the fetch side are carried along with the instruction and do nothing until that instruction is actually executed. This covers a failed fetch permission check and a fetch that came back with a bus error. A fault riding on an instruction that is dropped, such as one fetched down a discarded path, never produces a trap. Exceptions are precise and cannot be masked. The block has no enable input.

Every interface here is a plain control pin with one-cycle meaning. Nothing flows in a stream and the consumer cannot stall the block, so there is no back-pressure. A trap request that is not acted on in its cycle is simply gone.

Top module: `trap_prio_sel`

## Requirements
- R1: The cause word has bit 31 (interrupt flag) at 0 and all bits other than the low 6 at 0. The low 6 bits hold the exception code: fetch access fault 1, illegal instruction 2, breakpoint 3, load access fault 5, store/atomic access fault 7, machine environment call 11, fetch bus fault 48.
- R2: When several conditions are present together, the code reported is the first present one in this order: 1, 48, 2, 11, 3, 7, 5.
- R3: A fetch bus fault counts only when the fetch error flag and the fetch response-valid flag are both 1. An error flag with response-valid at 0 is ignored.
- R4: With the execute strobe at 0, no condition produces a trap, including the fetch access and fetch bus faults. The cause output stays unchanged.
- R5: A trap request is asserted in the cycle after a strobed instruction with at least one condition, and lasts exactly one cycle for that instruction. Strobed trapping instructions in consecutive cycles give trap requests in consecutive cycles.
- R6: After reset the trap request and the cause word are 0. The cause word changes only in a cycle where the trap request is asserted, and otherwise holds its last value.
- R7: A strobed instruction with no condition present gives no trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execution attempt for the instruction at the commit point |
| fetch_pma_fail_i | input | 1 | Fetch permission check failed for this instruction |
| fetch_err_i | input | 1 | Fetch response carried an error |
| fetch_rvalid_i | input | 1 | Fetch response-valid flag for the word |
| illegal_i | input | 1 | Illegal instruction |
| ecall_i | input | 1 | Machine environment call |
| ebreak_i | input | 1 | Breakpoint instruction |
| store_fault_i | input | 1 | Store, store-conditional or atomic access fault |
| load_fault_i | input | 1 | Load or load-reserved access fault |
| trap_valid_o | output | 1 | One-cycle trap request |
| trap_cause_o | output | 32 | Cause value for the machine cause register |

## Verification
The assertions assume that every condition input and the strobe hold a defined 0 or 1 at each rising edge. They also assume each strobed cycle stands for a different instruction, so consecutive pulses are legal and are never taken as a repeat. The stimulus changes inputs only on falling edges and always drives every pin to a known level. It walks all 128 combinations of the seven conditions with the strobe high, with the response-valid flag both high and low, and again with the strobe low. Every one of these cycles is followed by the next instruction at once, with no idle gap.

// File: rtl/trap_prio_pkg.sv
`timescale 1ns/1ps
package trap_prio_pkg;
  localparam int CODE_W  = 6;
  localparam int NUM_SRC = 7;

  // Source index doubles as priority rank: lower index wins.
  typedef enum int {
    SRC_FETCH_ACC = 0,
    SRC_FETCH_BUS = 1,
    SRC_ILLEGAL   = 2,
    SRC_ECALL     = 3,
    SRC_EBREAK    = 4,
    SRC_STORE     = 5,
    SRC_LOAD      = 6
  } src_e;

  localparam logic [CODE_W-1:0] CODE_FETCH_ACC = 6'd1;
  localparam logic [CODE_W-1:0] CODE_ILLEGAL   = 6'd2;
  localparam logic [CODE_W-1:0] CODE_EBREAK    = 6'd3;
  localparam logic [CODE_W-1:0] CODE_LOAD      = 6'd5;
  localparam logic [CODE_W-1:0] CODE_STORE     = 6'd7;
  localparam logic [CODE_W-1:0] CODE_ECALL     = 6'd11;
  localparam logic [CODE_W-1:0] CODE_FETCH_BUS = 6'd48;

  function automatic logic [CODE_W-1:0] code_of(input int idx);
    case (idx)
      SRC_FETCH_ACC: code_of = CODE_FETCH_ACC;
      SRC_FETCH_BUS: code_of = CODE_FETCH_BUS;
      SRC_ILLEGAL:   code_of = CODE_ILLEGAL;
      SRC_ECALL:     code_of = CODE_ECALL;
      SRC_EBREAK:    code_of = CODE_EBREAK;
      SRC_STORE:     code_of = CODE_STORE;
      SRC_LOAD:      code_of = CODE_LOAD;
      default:       code_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/trap_src_gather.sv
`timescale 1ns/1ps
module trap_src_gather
  import trap_prio_pkg::*;
(
  input  logic               exec_i,
  input  logic               fetch_pma_fail_i,
  input  logic               fetch_err_i,
  input  logic               fetch_rvalid_i,
  input  logic               illegal_i,
  input  logic               ecall_i,
  input  logic               ebreak_i,
  input  logic               store_fault_i,
  input  logic               load_fault_i,
  output logic [NUM_SRC-1:0] req_o
);
  logic [NUM_SRC-1:0] raw;

  // A bus fault belongs to a word only when its response was valid.
  always_comb begin
    raw                = '0;
    raw[SRC_FETCH_ACC] = fetch_pma_fail_i;
    raw[SRC_FETCH_BUS] = fetch_err_i & fetch_rvalid_i;
    raw[SRC_ILLEGAL]   = illegal_i;
    raw[SRC_ECALL]     = ecall_i;
    raw[SRC_EBREAK]    = ebreak_i;
    raw[SRC_STORE]     = store_fault_i;
    raw[SRC_LOAD]      = load_fault_i;
  end

  // Nothing, fetch-side faults included, is raised without an execution attempt.
  assign req_o = exec_i ? raw : '0;
endmodule

// File: rtl/trap_prio_pick.sv
`timescale 1ns/1ps
module trap_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_rank
      if (i == 0) begin : g_top
        assign grant_o[i] = req_i[i];
      end else begin : g_rest
        assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
      end
    end
  endgenerate

  // R2: at most one winner, and a winner exists whenever anything is requested
  always_comb begin
    p_onehot_r2: assert ($onehot0(grant_o) && ((|grant_o) == (|req_i)))
      else $error("p_onehot_r2: grant %b for req %b", grant_o, req_i);
  end
endmodule

// File: rtl/trap_cause_fmt.sv
`timescale 1ns/1ps
module trap_cause_fmt
  import trap_prio_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input  logic [NUM_SRC-1:0] grant_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int PAD_W = CAUSE_W - 1 - CODE_W;

  logic [CODE_W-1:0] code;

  always_comb begin
    code = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (grant_i[k]) code = code | code_of(k);
    end
  end

  assign any_o   = |grant_i;
  // Synchronous exceptions only: interrupt flag in the top bit is always 0.
  assign cause_o = {1'b0, {PAD_W{1'b0}}, code};
endmodule

// File: rtl/trap_prio_sel.sv
`timescale 1ns/1ps
module trap_prio_sel
  import trap_prio_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  logic               fetch_pma_fail_i,
  input  logic               fetch_err_i,
  input  logic               fetch_rvalid_i,
  input  logic               illegal_i,
  input  logic               ecall_i,
  input  logic               ebreak_i,
  input  logic               store_fault_i,
  input  logic               load_fault_i,
  output logic               trap_valid_o,
  output logic [CAUSE_W-1:0] trap_cause_o
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic               any_hit;
  logic [CAUSE_W-1:0] cause_nxt;

  trap_src_gather u_gather (
    .exec_i           (exec_i),
    .fetch_pma_fail_i (fetch_pma_fail_i),
    .fetch_err_i      (fetch_err_i),
    .fetch_rvalid_i   (fetch_rvalid_i),
    .illegal_i        (illegal_i),
    .ecall_i          (ecall_i),
    .ebreak_i         (ebreak_i),
    .store_fault_i    (store_fault_i),
    .load_fault_i     (load_fault_i),
    .req_o            (req)
  );

  trap_prio_pick #(.N(NUM_SRC)) u_pick (
    .req_i   (req),
    .grant_o (grant)
  );

  trap_cause_fmt #(.CAUSE_W(CAUSE_W)) u_fmt (
    .grant_i (grant),
    .any_o   (any_hit),
    .cause_o (cause_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid_o <= 1'b0;
      trap_cause_o <= '0;
    end else begin
      trap_valid_o <= any_hit;
      if (any_hit) trap_cause_o <= cause_nxt;
    end
  end

  // R4 / R5: a trap request only follows an execution attempt
  p_valid_needs_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid_o |-> $past(exec_i))
    else $error("p_valid_needs_exec_r4");

  // R6: cause word moves only together with a trap request
  p_cause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid_o |-> $stable(trap_cause_o))
    else $error("p_cause_hold_r6");

  // R1: a reported cause is one of the seven legal encodings
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid_o |-> (trap_cause_o == 1 || trap_cause_o == 2 || trap_cause_o == 3 ||
                      trap_cause_o == 5 || trap_cause_o == 7 || trap_cause_o == 11 ||
                      trap_cause_o == 48))
    else $error("p_code_legal_r1");

  // R3: a bus-fault report needs both error and response-valid on the previous cycle
  p_bus_needs_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid_o && trap_cause_o == 48) |-> $past(fetch_err_i && fetch_rvalid_i))
    else $error("p_bus_needs_rvalid_r3");

  // R7: a strobed clean instruction never produces a trap request
  p_clean_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !fetch_pma_fail_i && !(fetch_err_i && fetch_rvalid_i) && !illegal_i &&
     !ecall_i && !ebreak_i && !store_fault_i && !load_fault_i) |=> !trap_valid_o)
    else $error("p_clean_no_trap_r7");
endmodule

// File: tb/trap_prio_sel_bench.sv
`timescale 1ns/1ps
module trap_prio_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic        fetch_pma_fail_i = 1'b0;
  logic        fetch_err_i = 1'b0;
  logic        fetch_rvalid_i = 1'b0;
  logic        illegal_i = 1'b0;
  logic        ecall_i = 1'b0;
  logic        ebreak_i = 1'b0;
  logic        store_fault_i = 1'b0;
  logic        load_fault_i = 1'b0;
  logic        trap_valid_o;
  logic [31:0] trap_cause_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        q_valid[$];
  logic [31:0] q_cause[$];
  string       q_tag[$];
  logic [31:0] exp_cause = '0;

  always #4 clk = ~clk;  // 125 MHz

  trap_prio_sel u_trap_prio_sel (
    .clk              (clk),
    .rst_n            (rst_n),
    .exec_i           (exec_i),
    .fetch_pma_fail_i (fetch_pma_fail_i),
    .fetch_err_i      (fetch_err_i),
    .fetch_rvalid_i   (fetch_rvalid_i),
    .illegal_i        (illegal_i),
    .ecall_i          (ecall_i),
    .ebreak_i         (ebreak_i),
    .store_fault_i    (store_fault_i),
    .load_fault_i     (load_fault_i),
    .trap_valid_o     (trap_valid_o),
    .trap_cause_o     (trap_cause_o)
  );

  // Flag bits: 0 fetch access, 1 fetch error, 2 illegal, 3 ecall, 4 ebreak, 5 store, 6 load
  function automatic logic [31:0] ref_code(input logic [6:0] f, input logic rv);
    if (f[0])            return 32'd1;
    else if (f[1] && rv) return 32'd48;
    else if (f[2])       return 32'd2;
    else if (f[3])       return 32'd11;
    else if (f[4])       return 32'd3;
    else if (f[5])       return 32'd7;
    else if (f[6])       return 32'd5;
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: drive one instruction on a falling edge, push its expected result
  task automatic step(input logic [6:0] f, input logic ex, input logic rv, input string tag);
    logic [31:0] c;
    logic        hit;
    @(negedge clk);
    exec_i           = ex;
    fetch_pma_fail_i = f[0];
    fetch_err_i      = f[1];
    fetch_rvalid_i   = rv;
    illegal_i        = f[2];
    ecall_i          = f[3];
    ebreak_i         = f[4];
    store_fault_i    = f[5];
    load_fault_i     = f[6];
    c   = ref_code(f, rv);
    hit = ex && (c != 0);
    if (hit) exp_cause = c;
    q_valid.push_back(hit);
    q_cause.push_back(exp_cause);
    q_tag.push_back(tag);
  endtask

  // Monitor: after each rising edge, compare the registered outputs
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_valid.size() > 0) begin
        logic        v;
        logic [31:0] c;
        string       t;
        v = q_valid.pop_front();
        c = q_cause.pop_front();
        t = q_tag.pop_front();
        check({t, " valid"}, {31'd0, trap_valid_o}, {31'd0, v});
        check({t, " cause"}, trap_cause_o, c);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R6 reset valid", {31'd0, trap_valid_o}, 32'd0);
    check("R6 reset cause", trap_cause_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: strobed, nothing flagged
    step(7'd0, 1'b1, 1'b1, "R7 clean");
    // R1: each condition alone
    for (int b = 0; b < 7; b++) step(7'(1 << b), 1'b1, 1'b1, "R1 single");
    // R2 / R5: every subset, strobe high, back to back
    for (int m = 0; m < 128; m++) step(7'(m), 1'b1, 1'b1, "R2 subset");
    // R3: error flag without response-valid is ignored
    for (int m = 0; m < 128; m++) step(7'(m), 1'b1, 1'b0, "R3 no rvalid");
    step(7'b0000010, 1'b1, 1'b1, "R3 bus fault");
    step(7'b0000010, 1'b1, 1'b0, "R3 err alone");
    // R4: no strobe, nothing traps, cause holds
    for (int m = 0; m < 128; m++) step(7'(m), 1'b0, 1'b1, "R4 no exec");
    // R5: alternating trap / clean / trap
    step(7'b0100000, 1'b1, 1'b1, "R5 pulse a");
    step(7'b0000000, 1'b1, 1'b1, "R5 gap");
    step(7'b1000000, 1'b1, 1'b1, "R5 pulse b");
    step(7'b0000001, 1'b0, 1'b1, "R6 hold");
    step(7'b0000000, 1'b0, 1'b0, "R6 idle");

    while (q_valid.size() > 0) @(posedge clk);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule